// File: doc/BRIEF.md
# Counter-Based LRU Replacement

This block holds the replacement state of one set in an N-way set-associative cache (four ways by default). Each way owns a rank counter of log2(N) bits. Ranks always form a permutation of 0 to N-1: rank N-1 marks the most recently used way and rank 0 marks the least recently used way. The cache controller reports every access as a valid pulse together with a way index. The block then moves the accessed way to the top rank. Every way that ranked above the accessed way's old rank moves down by one step.

The victim output names the way that holds rank 0, and it is derived combinationally from the current ranks. The block never sees tags, data or hit logic; it handles way indices only. When a line is filled into the victim way, the controller must report that fill as an access so that the filled way becomes most recently used. To cover many sets, either replicate the block or keep the rank vector per set in an external array; the rank vector is brought out for that purpose.

Each way runs a small per-cycle action machine with three named actions. PROMOTE applies when the way is the one accessed, and the way's rank goes to N-1. DEMOTE applies when another way is accessed and this way's rank is strictly above that way's old rank, and the rank drops by one. HOLD applies in every other case, and the rank keeps its value. The choice is made afresh every cycle, and each action returns to the decision point at the next edge.

Top module: `lru_rank_set`

## Requirements
- R1: After reset, way i holds rank i for every way, so the victim is way 0.
- R2: In the cycle after a valid access to way W, the rank of way W equals WAYS-1.
- R3: On a valid access to way W whose old rank is X, every other way with rank strictly greater than X has its rank lowered by exactly one in the next cycle.
- R4: On a valid access to way W whose old rank is X, every other way with rank strictly below X keeps its rank.
- R5: victim_way equals the index of the way whose rank is 0, taken from the ranks held before any update in the same cycle.
- R6: The ranks of all ways always form a permutation of 0 to WAYS-1.
- R7: A cycle with acc_valid low leaves every rank unchanged.
- R8: A valid access to a way already at rank WAYS-1 leaves every rank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access to way acc_way takes place in this cycle |
| acc_way | input | IDXW | Index of the accessed way |
| victim_way | output | IDXW | Way with rank 0, the one to evict |
| rank_vec | output | WAYS*IDXW | Current ranks; way i occupies bits [i*IDXW +: IDXW] |

## Verification
The victim is due in the same cycle as the stimulus and reflects the ranks before the update, so the bench reads it 1 ns after it drives the inputs and before the next rising edge. Rank updates are due at the first rising edge after the access, and the bench samples rank_vec 1 ns after that edge. A behavioural reference model advances at that same edge. Every way's rank is compared against the model on every cycle. Each comparison is tagged with the requirement that governs that way: promote, demote, keep, idle, or access at the top rank.

// File: rtl/lru_rank_pkg.sv
`timescale 1ns/1ps
package lru_rank_pkg;

    // Per-way action chosen every cycle
    typedef enum logic [1:0] {
        RK_HOLD    = 2'd0,
        RK_DEMOTE  = 2'd1,
        RK_PROMOTE = 2'd2
    } rank_act_e;

endpackage

// File: rtl/lru_rank_cell.sv
`timescale 1ns/1ps
module lru_rank_cell
    import lru_rank_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int IDXW = 2,
    parameter int INIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            hit,
    input  logic [IDXW-1:0] pivot,
    output logic [IDXW-1:0] rank_q
);

    localparam logic [IDXW-1:0] TOP   = IDXW'(WAYS - 1);
    localparam logic [IDXW-1:0] START = IDXW'(INIT);

    rank_act_e act;

    // action decision
    always_comb begin
        if (acc_valid && hit) begin
            act = RK_PROMOTE;
        end else if (acc_valid && (rank_q > pivot)) begin
            act = RK_DEMOTE;
        end else begin
            act = RK_HOLD;
        end
    end

    // rank register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rank_q <= START;
        end else begin
            unique case (act)
                RK_PROMOTE: rank_q <= TOP;
                RK_DEMOTE:  rank_q <= rank_q - IDXW'(1);
                RK_HOLD:    rank_q <= rank_q;
                default:    rank_q <= rank_q;
            endcase
        end
    end

endmodule

// File: rtl/lru_victim_pick.sv
`timescale 1ns/1ps
module lru_victim_pick #(
    parameter int WAYS = 4,
    parameter int IDXW = 2
) (
    input  logic [WAYS*IDXW-1:0] ranks,
    output logic [IDXW-1:0]      victim
);

    always_comb begin
        victim = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ranks[i*IDXW +: IDXW] == '0) begin
                victim = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/lru_rank_set.sv
`timescale 1ns/1ps
module lru_rank_set #(
    parameter int WAYS = 4,
    localparam int IDXW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [IDXW-1:0]      acc_way,
    output logic [IDXW-1:0]      victim_way,
    output logic [WAYS*IDXW-1:0] rank_vec
);

    logic [IDXW-1:0] rank [WAYS];
    logic [IDXW-1:0] pivot;

    // old rank of the accessed way
    assign pivot = rank[acc_way];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        lru_rank_cell #(
            .WAYS (WAYS),
            .IDXW (IDXW),
            .INIT (g)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_valid (acc_valid),
            .hit       (acc_way == IDXW'(g)),
            .pivot     (pivot),
            .rank_q    (rank[g])
        );
        assign rank_vec[g*IDXW +: IDXW] = rank[g];
    end

    lru_victim_pick #(
        .WAYS (WAYS),
        .IDXW (IDXW)
    ) u_pick (
        .ranks  (rank_vec),
        .victim (victim_way)
    );

endmodule

// File: rtl/lru_rank_chk.sv
`timescale 1ns/1ps
module lru_rank_chk #(
    parameter int WAYS = 4,
    parameter int IDXW = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic [IDXW-1:0]      acc_way,
    input logic [IDXW-1:0]      victim_way,
    input logic [WAYS*IDXW-1:0] rank_vec
);

    localparam logic [IDXW-1:0] TOP = IDXW'(WAYS - 1);

    logic [IDXW-1:0] rk [WAYS];
    logic [WAYS-1:0] seen;

    always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++) begin
            rk[i] = rank_vec[i*IDXW +: IDXW];
            seen[rk[i]] = 1'b1;
        end
    end

    a_r6_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

    a_r5_victim_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rk[victim_way] == '0);

    a_r2_promote: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rk[$past(acc_way)] == TOP);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(rank_vec));

    a_r8_top_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && rk[acc_way] == TOP) |=> $stable(rank_vec));

    for (genvar g = 0; g < WAYS; g++) begin : g_chk
        a_r3_demote: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_way != IDXW'(g) && rk[g] > rk[acc_way])
            |=> rk[g] == $past(rk[g]) - IDXW'(1));

        a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_way != IDXW'(g) && rk[g] < rk[acc_way])
            |=> $stable(rk[g]));
    end

endmodule

bind lru_rank_set lru_rank_chk #(
    .WAYS (WAYS),
    .IDXW (IDXW)
) u_rank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .rank_vec   (rank_vec)
);

// File: tb/tb_lru_rank_set.sv
`timescale 1ns/1ps
module tb_lru_rank_set;

    localparam int WAYS = 4;
    localparam int IDXW = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 acc_valid = 1'b0;
    logic [IDXW-1:0]      acc_way = '0;
    logic [IDXW-1:0]      victim_way;
    logic [WAYS*IDXW-1:0] rank_vec;

    int  ref_rank [WAYS];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    int  lcg = 12345;

    always #2 clk = ~clk;   // 250 MHz

    lru_rank_set #(.WAYS(WAYS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_way    (acc_way),
        .victim_way (victim_way),
        .rank_vec   (rank_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_victim();
        int v = -1;
        foreach (ref_rank[i]) if (ref_rank[i] == 0) v = i;
        return v;
    endfunction

    function automatic int dut_rank(input int i);
        return int'(rank_vec[i*IDXW +: IDXW]);
    endfunction

    // one clock cycle of stimulus with checks
    task automatic step(input bit v, input int w);
        int old [WAYS];
        int x;
        int mask;
        @(negedge clk);
        acc_valid = v;
        acc_way   = IDXW'(w);
        #1;
        chk("R5 victim before update", int'(victim_way), ref_victim());
        old = ref_rank;
        x = old[w];
        if (v) begin
            for (int i = 0; i < WAYS; i++) begin
                if (i == w) ref_rank[i] = WAYS - 1;
                else if (old[i] > x) ref_rank[i] = old[i] - 1;
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < WAYS; i++) begin
            string tag;
            if (!v)                 tag = "R7 idle hold";
            else if (x == WAYS - 1) tag = "R8 top access no-op";
            else if (i == w)        tag = "R2 promote";
            else if (old[i] > x)    tag = "R3 demote";
            else                    tag = "R4 keep";
            chk($sformatf("%s way%0d", tag, i), dut_rank(i), ref_rank[i]);
        end
        mask = 0;
        for (int i = 0; i < WAYS; i++) mask |= (1 << dut_rank(i));
        chk("R6 permutation mask", mask, (1 << WAYS) - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WAYS; i++) ref_rank[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int i = 0; i < WAYS; i++) chk($sformatf("R1 reset rank way%0d", i), dut_rank(i), i);
        chk("R1 reset victim", int'(victim_way), 0);

        // idle cycles
        step(0, 0); step(0, 3);
        // access each way in ascending and descending order
        for (int i = 0; i < WAYS; i++) step(1, i);
        for (int i = WAYS - 1; i >= 0; i--) step(1, i);
        // repeated access to the most recent way
        step(1, 0); step(1, 0); step(1, 0);
        // middle-rank access
        step(1, 2); step(1, 1); step(0, 1);
        // fill victim repeatedly
        for (int k = 0; k < 8; k++) step(1, ref_victim());
        // pseudo-random mix
        for (int k = 0; k < 300; k++) begin
            lcg = lcg * 1103515245 + 12345;
            step(((lcg >>> 16) & 3) != 0, (lcg >>> 20) & (WAYS - 1));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule